// File: doc/BRIEF.md
# Audio Clock Mode Control Front End

This block holds the configuration of a multi-output audio clock generator and runs entirely on the 27 MHz master clock. A strap input chooses how the configuration arrives. With the strap low, three shared pins form a serial port: a shift clock, a data line and a load strobe. A 16-bit control word is shifted in and committed on the strobe. With the strap high, the same three pins are read directly as a two-bit sampling-group code and a one-bit rate select, and every clock output is enabled.

The block drives a group code (48 kHz, 44.1 kHz or 32 kHz family), a standard/double rate flag and six clock-output enables. Whenever the group or rate changes, it emits a one-cycle notice so that the divider logic downstream can restart its settling interval. Either of two active-low resets (an external pin and a power-on source) forces the default settings. Those defaults stay in force until 1024 master clocks after both resets have gone high.

Top module: `clkmode_ctrl`

## Requirements
- R1: `mode_hw` low makes the pins a serial port (`pin_a` load strobe, `pin_b` shift clock, `pin_c` data). `mode_hw` high makes them straps (`pin_a` rate, `pin_b` group bit 1, `pin_c` group bit 0), and shift-clock or strobe activity then loads nothing.
- R2: In serial mode the data line is sampled on every rising edge of the shift clock, most significant bit first. A rising edge of the load strobe commits the last 16 bits received. Without a commit the settings do not change.
- R3: Control word fields: bits 1:0 are the group code, bits 3:2 the rate code, and bits 9:4 the enables. Bit 4 drives `out_en[0]` (fixed 33.8688 MHz output), and bits 5..9 drive `out_en[1]..out_en[5]` (256fS, 384fS, 768fS, true 27 MHz, inverted 27 MHz). An enable bit of 1 turns its output on.
- R4: Group code 00 = 48 kHz, 01 = 44.1 kHz, 10 = 32 kHz. A word carrying 11 is rejected whole, and `grp_sel` never shows 11.
- R5: Rate code 00 = standard (`dbl_rate` = 0) and 01 = double (`dbl_rate` = 1). A word carrying 10 or 11 is rejected whole.
- R6: Bits 15:10 of the word must equal 011100. Any other value rejects the word and keeps the previous settings.
- R7: When more than 16 bits are shifted before a commit, only the last 16 count.
- R8: In strap mode the group follows `{pin_b,pin_c}` and the rate follows `pin_a`, with all six enables at 1. Group code 11 on the straps keeps the last valid group.
- R9: While reset is active or being stretched, the outputs hold 48 kHz group, standard rate and all enables on. Serial activity in that period is ignored.
- R10: `rst_busy` goes high at once when `ext_rst_n` or `por_n` is low. It falls exactly 1024 master-clock edges after the later of the two rises.
- R11: `cfg_pulse` is high for the single cycle in which a new group or rate first appears on the outputs. It stays low when only enables change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | 27 MHz master clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mode_hw | input | 1 | Strap select: 1 = strap mode, 0 = serial mode |
| pin_a | input | 1 | Load strobe (serial) or rate strap |
| pin_b | input | 1 | Shift clock (serial) or group bit 1 strap |
| pin_c | input | 1 | Serial data (serial) or group bit 0 strap |
| grp_sel | output | 2 | Sampling group code |
| dbl_rate | output | 1 | 1 = double rate |
| out_en | output | 6 | Per-output clock enables |
| cfg_pulse | output | 1 | One-cycle notice of a group or rate change |
| rst_busy | output | 1 | Internal reset (including stretch) active |

## Verification
A single commit can update the enables and the group/rate pair in the same cycle, and the change notice must fire in exactly that cycle. The bench provokes this with a word that changes both fields, then with a word that changes only enables. The scoreboard pops one expected item each time the outputs change and compares the values together with the expected state of `cfg_pulse`. Straps are moved in strap mode to change group and rate together in one cycle. A serial word is also sent during the stretch window, where reset and serial loading overlap, and the defaults must survive it.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  localparam int N_OUT    = 6;
  localparam int WORD_W   = 16;
  localparam int GRP_LSB  = 0;
  localparam int RATE_LSB = 2;
  localparam int EN_LSB   = 4;
  localparam int TAG_LSB  = EN_LSB + N_OUT;
  localparam int TAG_W    = WORD_W - TAG_LSB;
  localparam logic [TAG_W-1:0] WORD_TAG = 6'b011100;

  typedef enum logic [1:0] {
    GRP_48K  = 2'b00,
    GRP_44K1 = 2'b01,
    GRP_32K  = 2'b10,
    GRP_RSVD = 2'b11
  } grp_e;

  typedef struct packed {
    grp_e             grp;
    logic             dbl;
    logic [N_OUT-1:0] en;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{grp: GRP_48K, dbl: 1'b0, en: {N_OUT{1'b1}}};
endpackage

// File: rtl/cm_sync.sv
module cm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cm_rst_stretch.sv
module cm_rst_stretch #(
  parameter int CYCLES = 1024
) (
  input  logic clk,
  input  logic arst_n,
  output logic run
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run;
    if (!run) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(CYCLES - 1)) run_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      run   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run   <= run_d;
    end
  end

  // R10: once released, internal reset stays released until a reset input falls
  p_run_sticky_r10: assert property (@(posedge clk) disable iff (!arst_n)
    run |=> run);
endmodule

// File: rtl/cm_serial_rx.sv
module cm_serial_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              active,
  input  logic              strobe_s,
  input  logic              sclk_s,
  input  logic              sdat_s,
  output logic [WORD_W-1:0] word,
  output logic              commit
);
  logic              sclk_q, strobe_q;
  logic              sclk_rise, strobe_rise;
  logic [WORD_W-1:0] word_d;

  assign sclk_rise   = sclk_s & ~sclk_q;
  assign strobe_rise = strobe_s & ~strobe_q;
  assign commit      = active & strobe_rise;

  always_comb begin
    word_d = word;
    if (active && sclk_rise) word_d = {word[WORD_W-2:0], sdat_s};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sclk_q   <= 1'b0;
      strobe_q <= 1'b0;
      word     <= '0;
    end else begin
      sclk_q   <= sclk_s;
      strobe_q <= strobe_s;
      word     <= word_d;
    end
  end
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
#(
  parameter int STRETCH_CYCLES = 1024,
  parameter int SYNC_STAGES    = 2
) (
  input  logic             clk_mst,
  input  logic             ext_rst_n,
  input  logic             por_n,
  input  logic             mode_hw,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic             pin_c,
  output logic [1:0]       grp_sel,
  output logic             dbl_rate,
  output logic [N_OUT-1:0] out_en,
  output logic             cfg_pulse,
  output logic             rst_busy
);
  logic              arst_n;
  logic              run;
  logic              hw_s, a_s, b_s, c_s;
  logic [WORD_W-1:0] word;
  logic              commit;
  logic              word_ok;
  cfg_t              cfg_q, cfg_d;
  logic              pulse_d;

  assign arst_n = ext_rst_n & por_n;

  cm_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk_mst),
    .arst_n (arst_n),
    .d      ({mode_hw, pin_a, pin_b, pin_c}),
    .q      ({hw_s, a_s, b_s, c_s})
  );

  cm_rst_stretch #(.CYCLES(STRETCH_CYCLES)) u_stretch (
    .clk    (clk_mst),
    .arst_n (arst_n),
    .run    (run)
  );

  cm_serial_rx #(.WORD_W(WORD_W)) u_rx (
    .clk      (clk_mst),
    .arst_n   (arst_n),
    .active   (run & ~hw_s),
    .strobe_s (a_s),
    .sclk_s   (b_s),
    .sdat_s   (c_s),
    .word     (word),
    .commit   (commit)
  );

  // word acceptance: tag, group and rate fields must all be legal
  assign word_ok = (word[TAG_LSB +: TAG_W] == WORD_TAG)
                && (word[GRP_LSB +: 2] != GRP_RSVD)
                && (word[RATE_LSB + 1] == 1'b0);

  always_comb begin
    cfg_d = cfg_q;
    if (!run) begin
      cfg_d = CFG_RESET;
    end else if (hw_s) begin
      if ({b_s, c_s} != GRP_RSVD) cfg_d.grp = grp_e'({b_s, c_s});
      cfg_d.dbl = a_s;
      cfg_d.en  = {N_OUT{1'b1}};
    end else if (commit && word_ok) begin
      cfg_d.grp = grp_e'(word[GRP_LSB +: 2]);
      cfg_d.dbl = word[RATE_LSB];
      cfg_d.en  = word[EN_LSB +: N_OUT];
    end
    pulse_d = run && ((cfg_d.grp != cfg_q.grp) || (cfg_d.dbl != cfg_q.dbl));
  end

  always_ff @(posedge clk_mst or negedge arst_n) begin
    if (!arst_n) begin
      cfg_q     <= CFG_RESET;
      cfg_pulse <= 1'b0;
    end else begin
      cfg_q     <= cfg_d;
      cfg_pulse <= pulse_d;
    end
  end

  assign grp_sel  = cfg_q.grp;
  assign dbl_rate = cfg_q.dbl;
  assign out_en   = cfg_q.en;
  assign rst_busy = ~run;

  // R4: the reserved group code never reaches the output
  p_grp_legal_r4: assert property (@(posedge clk_mst) disable iff (!arst_n)
    grp_sel != 2'b11);

  // R9: defaults held for the whole reset and stretch period
  p_reset_defaults_r9: assert property (@(posedge clk_mst) disable iff (!arst_n)
    rst_busy |-> (grp_sel == 2'b00 && !dbl_rate && &out_en));

  // R8: strap mode keeps every output enabled
  p_hw_all_on_r8: assert property (@(posedge clk_mst) disable iff (!arst_n)
    (hw_s && $past(hw_s)) |-> &out_en);

  // R2: in serial mode nothing changes without a commit
  p_sw_hold_r2: assert property (@(posedge clk_mst) disable iff (!arst_n)
    (run && !hw_s && !commit) |=> ($stable(grp_sel) && $stable(dbl_rate) && $stable(out_en)));

  // R11: a notice only accompanies a real group or rate change
  p_pulse_cause_r11: assert property (@(posedge clk_mst) disable iff (!arst_n)
    cfg_pulse |-> ((grp_sel != $past(grp_sel)) || (dbl_rate != $past(dbl_rate))));

  // R11: every group or rate change carries a notice
  p_change_flag_r11: assert property (@(posedge clk_mst) disable iff (!arst_n)
    ((grp_sel != $past(grp_sel)) || (dbl_rate != $past(dbl_rate))) |-> cfg_pulse);
endmodule

// File: tb/sim_clkmode_ctrl.sv
module sim_clkmode_ctrl;
  typedef struct {
    logic [1:0] g;
    logic       d;
    logic [5:0] e;
    logic       p;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       ext_rst_n, por_n, mode_hw, pin_a, pin_b, pin_c;
  logic [1:0] grp_sel;
  logic       dbl_rate;
  logic [5:0] out_en;
  logic       cfg_pulse, rst_busy;

  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 1'b0;
  bit mon_en = 1'b0;
  int cyc_since = 0;

  item_t      q_exp[$];
  logic [1:0] m_g;
  logic       m_d;
  logic [5:0] m_e;
  logic [8:0] last_seen;

  always #4 clk = ~clk;

  clkmode_ctrl u0 (
    .clk_mst (clk), .ext_rst_n (ext_rst_n), .por_n (por_n), .mode_hw (mode_hw),
    .pin_a (pin_a), .pin_b (pin_b), .pin_c (pin_c),
    .grp_sel (grp_sel), .dbl_rate (dbl_rate), .out_en (out_en),
    .cfg_pulse (cfg_pulse), .rst_busy (rst_busy)
  );

  always @(posedge clk) begin
    if (!(ext_rst_n && por_n)) cyc_since <= 0;
    else cyc_since <= cyc_since + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // driver side of the scoreboard: model update and expected item
  task automatic expect_cfg(input logic [1:0] g, input logic d, input logic [5:0] e, input string tag);
    item_t it;
    if (g != m_g || d != m_d || e != m_e) begin
      it.g = g; it.d = d; it.e = e; it.p = (g != m_g) || (d != m_d); it.tag = tag;
      q_exp.push_back(it);
      m_g = g; m_d = d; m_e = e;
    end
  endtask

  task automatic model_reset();
    m_g = 2'b00; m_d = 1'b0; m_e = 6'h3f;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] mkword(input logic [5:0] tag, input logic [5:0] en,
                                         input logic [1:0] rate, input logic [1:0] grp);
    return {tag, en, rate, grp};
  endfunction

  task automatic shift_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      pin_c = bits[i];
      wait_n(4);
      pin_b = 1'b1;
      wait_n(4);
      pin_b = 1'b0;
      wait_n(4);
    end
    pin_a = 1'b1;
    wait_n(4);
    pin_a = 1'b0;
    wait_n(6);
  endtask

  task automatic check_model(input string req, input string what);
    check({grp_sel, dbl_rate, out_en} == {m_g, m_d, m_e}, req, what,
          32'({grp_sel, dbl_rate, out_en}), 32'({m_g, m_d, m_e}));
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (mon_en) begin
      if (rst_busy) begin
        last_seen = {grp_sel, dbl_rate, out_en};
      end else if ({grp_sel, dbl_rate, out_en} != last_seen) begin
        if (q_exp.size() == 0) begin
          check(1'b0, "R2", "unexpected settings change", 32'({grp_sel, dbl_rate, out_en}), 32'(last_seen));
        end else begin
          item_t it;
          it = q_exp.pop_front();
          check({grp_sel, dbl_rate, out_en} == {it.g, it.d, it.e}, it.tag, "settings",
                32'({grp_sel, dbl_rate, out_en}), 32'({it.g, it.d, it.e}));
          check(cfg_pulse == it.p, "R11", "change notice", 32'(cfg_pulse), 32'(it.p));
        end
        last_seen = {grp_sel, dbl_rate, out_en};
      end else if (cfg_pulse) begin
        check(1'b0, "R11", "notice without change", 32'(cfg_pulse), 32'd0);
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    report();
  end

  initial begin
    ext_rst_n = 1'b0; por_n = 1'b0; mode_hw = 1'b0;
    pin_a = 1'b0; pin_b = 1'b0; pin_c = 1'b0;
    model_reset();
    wait_n(5);
    // R9 reset state
    check_model("R9", "defaults in reset");
    check(rst_busy == 1'b1, "R10", "busy in reset", 32'(rst_busy), 32'd1);
    por_n = 1'b1;
    wait_n(1200);
    check(rst_busy == 1'b1, "R10", "busy while ext reset low", 32'(rst_busy), 32'd1);
    ext_rst_n = 1'b1;
    // R9: serial word during stretch is ignored
    shift_bits(32'(mkword(6'b011100, 6'b000001, 2'b01, 2'b10)), 16);
    while (cyc_since < 1023) @(negedge clk);
    check(rst_busy == 1'b1, "R10", "busy after 1023 edges", 32'(rst_busy), 32'd1);
    @(negedge clk);
    check(rst_busy == 1'b0, "R10", "released after 1024 edges", 32'(rst_busy), 32'd0);
    check_model("R9", "stretch-time word ignored");
    last_seen = {grp_sel, dbl_rate, out_en};
    mon_en = 1'b1;

    // R2 R3: group, rate and enables together
    expect_cfg(2'b01, 1'b1, 6'b101101, "R3");
    shift_bits(32'(mkword(6'b011100, 6'b101101, 2'b01, 2'b01)), 16);
    // R11: enables only
    expect_cfg(2'b01, 1'b1, 6'b010010, "R11");
    shift_bits(32'(mkword(6'b011100, 6'b010010, 2'b01, 2'b01)), 16);
    // R6: bad tag
    shift_bits(32'(mkword(6'b011101, 6'b111111, 2'b00, 2'b10)), 16);
    check_model("R6", "bad tag rejected");
    // R4: reserved group
    shift_bits(32'(mkword(6'b011100, 6'b111111, 2'b00, 2'b11)), 16);
    check_model("R4", "reserved group rejected");
    // R5: reserved rates
    shift_bits(32'(mkword(6'b011100, 6'b111111, 2'b10, 2'b00)), 16);
    check_model("R5", "rate 10 rejected");
    shift_bits(32'(mkword(6'b011100, 6'b111111, 2'b11, 2'b00)), 16);
    check_model("R5", "rate 11 rejected");
    // R7: 20 bits, last 16 count
    expect_cfg(2'b10, 1'b0, 6'b111000, "R7");
    shift_bits({12'h000, 4'b1111, mkword(6'b011100, 6'b111000, 2'b00, 2'b10)}, 20);
    // R2 R4: 48k standard with sparse enables
    expect_cfg(2'b00, 1'b0, 6'b000001, "R2");
    shift_bits(32'(mkword(6'b011100, 6'b000001, 2'b00, 2'b00)), 16);

    // R1 R8: strap mode
    mode_hw = 1'b1;
    expect_cfg(2'b00, 1'b0, 6'h3f, "R8");
    wait_n(8);
    expect_cfg(2'b10, 1'b1, 6'h3f, "R8");
    pin_b = 1'b1; pin_a = 1'b1;
    wait_n(8);
    pin_c = 1'b1;
    wait_n(8);
    check_model("R8", "strap group 11 holds");
    expect_cfg(2'b01, 1'b1, 6'h3f, "R1");
    pin_b = 1'b0;
    wait_n(8);
    expect_cfg(2'b00, 1'b0, 6'h3f, "R8");
    pin_a = 1'b0; pin_c = 1'b0;
    wait_n(8);
    mode_hw = 1'b0;
    wait_n(8);
    check_model("R1", "serial mode resumes");
    expect_cfg(2'b10, 1'b1, 6'b100110, "R1");
    shift_bits(32'(mkword(6'b011100, 6'b100110, 2'b01, 2'b10)), 16);

    // R10 R9: external reset mid-run
    ext_rst_n = 1'b0;
    #1;
    model_reset();
    check_model("R9", "async defaults on ext reset");
    check(rst_busy == 1'b1, "R10", "busy on ext reset", 32'(rst_busy), 32'd1);
    wait_n(4);
    ext_rst_n = 1'b1;
    wait_n(1030);
    check(rst_busy == 1'b0, "R10", "released after ext reset", 32'(rst_busy), 32'd0);
    expect_cfg(2'b01, 1'b0, 6'b011110, "R3");
    shift_bits(32'(mkword(6'b011100, 6'b011110, 2'b00, 2'b01)), 16);
    // R10: power-on reset has the same effect
    por_n = 1'b0;
    #1;
    model_reset();
    check_model("R10", "defaults on power-on reset");
    wait_n(4);
    por_n = 1'b1;
    wait_n(1030);
    check(rst_busy == 1'b0, "R10", "released after power-on reset", 32'(rst_busy), 32'd0);
    check_model("R9", "defaults after release");
    wait_n(4);
    check(q_exp.size() == 0, "R2", "all expected changes seen", 32'(q_exp.size()), 32'd0);
    report();
  end
endmodule